// File: doc/BRIEF.md
# Part-Number Record Extractor

This block fetches a board part-number record from a word-addressed nonvolatile store and turns it into a stream of ASCII bytes that ends with a null. It talks to the store through a single-outstanding read port. A request goes out with a valid/ready handshake, and the response arrives after any number of cycles, carrying a data word and an error flag. At the start pulse the block samples a guard word, the addresses of the two record words and the capacity of the caller's buffer. It reports completion with a one-cycle done pulse and a two-bit result code.

The record has two shapes, and the first word selects between them. When the first word differs from the guard, the two words hold packed hex digits. These are expanded to ten characters with a fixed dash and a fixed zero character. When the first word equals the guard, the second word points to a section. The section starts with a length word, and the string bytes follow it.

Top module: `pn_string_extract`

## Requirements
- R1: After start, the first read is at the first-word address and the second read is at the second-word address, in that order.
- R2: When the first word is not equal to the sampled guard, the stream is exactly 11 bytes. In order these are: the four nibbles of the first word, most significant first; the upper two nibbles of the second word; the dash 0x2D; the character 0x30; the lower two nibbles of the second word; then 0x00.
- R3: Each packed nibble n is sent as 0x30+n when n < 10, and as 0x41+(n-10) when n is 10 to 15 (uppercase).
- R4: In the packed format, a capacity below 11 ends the run with code 1 (no space) and sends no byte.
- R5: In the string format, the word at the pointer is the length. A length of 0x0000 or 0xFFFF ends the run with code 2 (bad section) and sends no byte.
- R6: In the string format, a capacity below 2*length-1 ends the run with code 1 and sends no byte.
- R7: In the string format, the words at pointer+1 through pointer+length-1 are read in rising order. Each is sent as its high byte and then its low byte, followed by one 0x00. A length of 1 gives only the 0x00.
- R8: A response with its error flag set ends the run with code 3. No further read is issued. Bytes sent before the failing read remain sent.
- R9: Every start gives exactly one done pulse, one cycle long, after the last byte. The code is valid on that cycle, and a successful run gives code 0.
- R10: While a request is valid but not accepted, the request stays valid and its address stays unchanged.
- R11: Under reset and right after it, the request valid, the byte valid and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an extraction (accepted when idle) |
| guard_word | input | 16 | Value that marks the string format |
| first_addr | input | AW | Address of the first record word |
| second_addr | input | AW | Address of the second record word |
| capacity | input | CAP_W | Caller buffer size in bytes |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read word address |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | 16 | Read data word |
| rd_rsp_err | input | 1 | Read failed |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output character |
| done | output | 1 | End-of-run pulse |
| err_code | output | 2 | 0 ok, 1 no space, 2 bad section, 3 read error |

## Verification
Packed records are tried with two word pairs chosen so that the digits 0, 9, A and F all appear, which separates the two conversion ranges. The same pair is also tried with the word addresses swapped, so the nibble order is visible. String records are tried with lengths of 3 and 1. A guard value equal to a normally packed word is used to show that the guard is taken from the input. Capacities set exactly at and one below each limit separate the acceptance rules. Lengths of 0 and 0xFFFF, and read failures injected at the first word, the length word and a mid-string word, show where a run stops and how many reads it issued. Response latency and request stalls vary between vectors to exercise the handshake.

// File: rtl/pn_pkg.sv
package pn_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_PACK,
        S_HI,
        S_LO,
        S_NULL,
        S_FIN
    } state_t;

    typedef enum logic [1:0] {
        PH_W0,
        PH_W1,
        PH_LEN,
        PH_STR
    } phase_t;

    localparam logic [1:0] RC_OK      = 2'd0;
    localparam logic [1:0] RC_NOSPACE = 2'd1;
    localparam logic [1:0] RC_BADSEC  = 2'd2;
    localparam logic [1:0] RC_RDERR   = 2'd3;

    localparam int PACK_CHARS = 11;

endpackage

// File: rtl/pn_hex_char.sv
module pn_hex_char (
    input  logic [3:0] nib,
    output logic [7:0] chr
);
    always_comb begin
        if (nib < 4'd10) chr = 8'h30 + {4'd0, nib};
        else             chr = 8'h41 + {4'd0, nib} - 8'd10;
    end

    // R3: the result always lies in the digit or uppercase-letter range
    always_comb begin
        a_r3_hex_range: assert ((chr >= 8'h30 && chr <= 8'h39) ||
                                (chr >= 8'h41 && chr <= 8'h46))
            else $error("hex char out of range");
    end
endmodule

// File: rtl/pn_cap_check.sv
module pn_cap_check #(
    parameter int CAP_W = 18
) (
    input  logic             string_mode,
    input  logic [15:0]      len,
    input  logic [CAP_W-1:0] capacity,
    output logic             fits
);
    localparam int TWICE_W = 17;
    localparam logic [CAP_W-1:0] PACK_NEED = CAP_W'(pn_pkg::PACK_CHARS);

    logic [TWICE_W-1:0] twice;
    logic [CAP_W-1:0]   need;

    always_comb begin
        twice = {len, 1'b0};
        need  = string_mode ? (CAP_W'(twice) - CAP_W'(1)) : PACK_NEED;
        fits  = (capacity >= need);
    end
endmodule

// File: rtl/pn_string_extract.sv
module pn_string_extract
    import pn_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CAP_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [15:0]      guard_word,
    input  logic [AW-1:0]    first_addr,
    input  logic [AW-1:0]    second_addr,
    input  logic [CAP_W-1:0] capacity,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [AW-1:0]    rd_req_addr,
    input  logic             rd_rsp_valid,
    input  logic [15:0]      rd_rsp_data,
    input  logic             rd_rsp_err,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             done,
    output logic [1:0]       err_code
);
    localparam int          PIDX_W    = $clog2(PACK_CHARS);
    localparam logic [PIDX_W-1:0] PIDX_LAST = PIDX_W'(PACK_CHARS - 1);

    typedef struct packed {
        state_t            st;
        phase_t            ph;
        logic [AW-1:0]     addr;
        logic [AW-1:0]     off2;
        logic [15:0]       guard;
        logic [CAP_W-1:0]  cap;
        logic [15:0]       w0;
        logic [15:0]       w1;
        logic [15:0]       data;
        logic [15:0]       remain;
        logic [PIDX_W-1:0] pidx;
        logic [7:0]        obyte;
        logic              ovalid;
        logic              done;
        logic [1:0]        err;
    } regs_t;

    regs_t q, d;

    logic [3:0] nib;
    logic [7:0] hex_chr;
    logic [7:0] pack_chr;
    logic       cap_fits;

    always_comb begin
        case (q.pidx)
            4'd0:    nib = q.w0[15:12];
            4'd1:    nib = q.w0[11:8];
            4'd2:    nib = q.w0[7:4];
            4'd3:    nib = q.w0[3:0];
            4'd4:    nib = q.w1[15:12];
            4'd5:    nib = q.w1[11:8];
            4'd8:    nib = q.w1[7:4];
            default: nib = q.w1[3:0];
        endcase
    end

    pn_hex_char u_hex (
        .nib (nib),
        .chr (hex_chr)
    );

    always_comb begin
        case (q.pidx)
            4'd6:    pack_chr = 8'h2D;
            4'd7:    pack_chr = 8'h30;
            4'd10:   pack_chr = 8'h00;
            default: pack_chr = hex_chr;
        endcase
    end

    pn_cap_check #(.CAP_W(CAP_W)) u_cap (
        .string_mode (q.ph == PH_LEN),
        .len         (rd_rsp_data),
        .capacity    (q.cap),
        .fits        (cap_fits)
    );

    always_comb begin
        d        = q;
        d.ovalid = 1'b0;
        d.done   = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.guard = guard_word;
                    d.cap   = capacity;
                    d.addr  = first_addr;
                    d.off2  = second_addr;
                    d.ph    = PH_W0;
                    d.err   = RC_OK;
                    d.st    = S_REQ;
                end
            end
            S_REQ: begin
                if (rd_req_ready) d.st = S_WAIT;
            end
            S_WAIT: begin
                if (rd_rsp_valid) begin
                    if (rd_rsp_err) begin
                        d.err = RC_RDERR;
                        d.st  = S_FIN;
                    end else begin
                        case (q.ph)
                            PH_W0: begin
                                d.w0   = rd_rsp_data;
                                d.addr = q.off2;
                                d.ph   = PH_W1;
                                d.st   = S_REQ;
                            end
                            PH_W1: begin
                                d.w1 = rd_rsp_data;
                                if (q.w0 != q.guard) begin
                                    if (cap_fits) begin
                                        d.pidx = '0;
                                        d.st   = S_PACK;
                                    end else begin
                                        d.err = RC_NOSPACE;
                                        d.st  = S_FIN;
                                    end
                                end else begin
                                    d.addr = AW'(rd_rsp_data);
                                    d.ph   = PH_LEN;
                                    d.st   = S_REQ;
                                end
                            end
                            PH_LEN: begin
                                if (rd_rsp_data == 16'h0000 || rd_rsp_data == 16'hFFFF) begin
                                    d.err = RC_BADSEC;
                                    d.st  = S_FIN;
                                end else if (!cap_fits) begin
                                    d.err = RC_NOSPACE;
                                    d.st  = S_FIN;
                                end else begin
                                    d.remain = rd_rsp_data - 16'd1;
                                    if (rd_rsp_data == 16'd1) begin
                                        d.st = S_NULL;
                                    end else begin
                                        d.addr = q.addr + AW'(1);
                                        d.ph   = PH_STR;
                                        d.st   = S_REQ;
                                    end
                                end
                            end
                            default: begin
                                d.data = rd_rsp_data;
                                d.st   = S_HI;
                            end
                        endcase
                    end
                end
            end
            S_PACK: begin
                d.ovalid = 1'b1;
                d.obyte  = pack_chr;
                d.pidx   = q.pidx + PIDX_W'(1);
                if (q.pidx == PIDX_LAST) d.st = S_FIN;
            end
            S_HI: begin
                d.ovalid = 1'b1;
                d.obyte  = q.data[15:8];
                d.st     = S_LO;
            end
            S_LO: begin
                d.ovalid = 1'b1;
                d.obyte  = q.data[7:0];
                d.remain = q.remain - 16'd1;
                if (q.remain == 16'd1) begin
                    d.st = S_NULL;
                end else begin
                    d.addr = q.addr + AW'(1);
                    d.st   = S_REQ;
                end
            end
            S_NULL: begin
                d.ovalid = 1'b1;
                d.obyte  = 8'h00;
                d.st     = S_FIN;
            end
            default: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req_valid = (q.st == S_REQ);
    assign rd_req_addr  = q.addr;
    assign out_valid    = q.ovalid;
    assign out_byte     = q.obyte;
    assign done         = q.done;
    assign err_code     = q.err;

    // R10: a stalled request keeps its address
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a failed response leads to done with the read-error code
    a_r8_read_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT) && rd_rsp_valid && rd_rsp_err |=> ##1 (done && err_code == RC_RDERR));

    // R5: a zero length word gives the bad-section code
    a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT) && (q.ph == PH_LEN) && rd_rsp_valid && !rd_rsp_err &&
        (rd_rsp_data == 16'h0000) |=> ##1 (done && err_code == RC_BADSEC));

    // R9: no byte is sent on the done cycle
    a_r9_no_byte_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);
endmodule

// File: tb/pn_string_extract_tb.sv
`timescale 1ns/1ps
module pn_string_extract_tb;
    localparam int AW    = 16;
    localparam int CAP_W = 18;

    typedef struct packed {
        logic [7:0]  off0;
        logic [7:0]  off1;
        logic [15:0] guard;
        logic [17:0] cap;
        logic [3:0]  lat;
        logic [8:0]  erra;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd0,  8'd1,  16'hFAFA, 18'd11, 4'd0, 9'h100}, // R2 R3 packed, cap exact
        '{8'd10, 8'd11, 16'hFAFA, 18'd40, 4'd3, 9'h100}, // R3 digits 0 9 A F
        '{8'd1,  8'd0,  16'hFAFA, 18'd20, 4'd1, 9'h100}, // R1 swapped order
        '{8'd0,  8'd1,  16'hFAFA, 18'd10, 4'd2, 9'h100}, // R4 cap one short
        '{8'd2,  8'd3,  16'hFAFA, 18'd5,  4'd1, 9'h100}, // R7 string len 3
        '{8'd2,  8'd3,  16'hFAFA, 18'd4,  4'd0, 9'h100}, // R6 cap one short
        '{8'd4,  8'd5,  16'hFAFA, 18'd99, 4'd2, 9'h100}, // R5 length 0
        '{8'd6,  8'd7,  16'hFAFA, 18'd99, 4'd0, 9'h100}, // R5 length FFFF
        '{8'd8,  8'd9,  16'hFAFA, 18'd1,  4'd1, 9'h100}, // R7 length 1
        '{8'd0,  8'd1,  16'h12AB, 18'd3,  4'd0, 9'h100}, // R2 guard from input
        '{8'd0,  8'd1,  16'hFAFA, 18'd20, 4'd1, 9'h000}, // R8 first read fails
        '{8'd2,  8'd3,  16'hFAFA, 18'd9,  4'd2, 9'h012}, // R8 mid-string fail
        '{8'd2,  8'd3,  16'hFAFA, 18'd9,  4'd0, 9'h010}, // R8 length read fails
        '{8'd2,  8'd3,  16'hFAFA, 18'd9,  4'd5, 9'h100}  // R10 long stalls
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [15:0]      guard_word = '0;
    logic [AW-1:0]    first_addr = '0;
    logic [AW-1:0]    second_addr = '0;
    logic [CAP_W-1:0] capacity = '0;
    logic             rd_req_valid;
    logic             rd_req_ready = 1'b0;
    logic [AW-1:0]    rd_req_addr;
    logic             rd_rsp_valid = 1'b0;
    logic [15:0]      rd_rsp_data = '0;
    logic             rd_rsp_err = 1'b0;
    logic             out_valid;
    logic [7:0]       out_byte;
    logic             done;
    logic [1:0]       err_code;

    always #5 clk = ~clk;

    pn_string_extract #(.AW(AW), .CAP_W(CAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .guard_word(guard_word),
        .first_addr(first_addr), .second_addr(second_addr), .capacity(capacity),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .out_valid(out_valid), .out_byte(out_byte), .done(done), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [0:255];
    logic [3:0]  cur_lat = '0;
    logic [8:0]  cur_erra = 9'h100;

    logic          busy = 1'b0;
    int            cnt = 0;
    logic [AW-1:0] addr_l = '0;
    logic          ph = 1'b0;
    logic          acc_prev = 1'b0;
    logic [AW-1:0] req_prev = '0;
    logic          hold_prev = 1'b0;
    logic [AW-1:0] hold_addr = '0;

    int          nreads = 0;
    int          ndone = 0;
    int          stab_bad = 0;
    logic [AW-1:0] a0 = '0;
    logic [AW-1:0] a1 = '0;
    logic [7:0]  got [0:63];
    int          ngot = 0;
    logic [1:0]  got_err = '0;

    logic [7:0]  expb [0:63];
    int          nexp = 0;
    int          exp_err = 0;
    int          exp_reads = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            busy = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_err = 1'b0;
            rd_req_ready = 1'b0; acc_prev = 1'b0; hold_prev = 1'b0;
        end else begin
            if (hold_prev && !(rd_req_valid && rd_req_addr == hold_addr)) stab_bad++;
            rd_rsp_valid = 1'b0;
            rd_rsp_err   = 1'b0;
            if (acc_prev) begin
                busy = 1'b1; cnt = int'(cur_lat); addr_l = req_prev;
            end else if (busy) begin
                if (cnt == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = mem[addr_l[7:0]];
                    rd_rsp_err   = !cur_erra[8] && (cur_erra[7:0] == addr_l[7:0]);
                    busy = 1'b0;
                end else begin
                    cnt--;
                end
            end
            ph = ~ph;
            rd_req_ready = !busy && !rd_rsp_valid && (ph || cur_lat == 4'd0);
            acc_prev = rd_req_valid && rd_req_ready;
            if (acc_prev) begin
                if (nreads == 0) a0 = rd_req_addr;
                if (nreads == 1) a1 = rd_req_addr;
                nreads++;
            end
            req_prev  = rd_req_addr;
            hold_prev = rd_req_valid && !rd_req_ready;
            hold_addr = rd_req_addr;
            if (out_valid && ngot < 64) begin got[ngot] = out_byte; ngot++; end
            if (done) begin ndone++; got_err = err_code; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'd0, n}) : (8'h37 + {4'd0, n});
    endfunction

    task automatic push(input logic [7:0] b);
        expb[nexp] = b; nexp++;
    endtask

    // expected result straight from the requirements
    task automatic model(input vec_t v);
        logic [15:0] w0, w1, len;
        logic [7:0]  p;
        nexp = 0; exp_err = 0;
        exp_reads = 1;
        if (!v.erra[8] && v.erra[7:0] == v.off0) begin exp_err = 3; return; end
        w0 = mem[v.off0];
        exp_reads = 2;
        if (!v.erra[8] && v.erra[7:0] == v.off1) begin exp_err = 3; return; end
        w1 = mem[v.off1];
        if (w0 != v.guard) begin
            if (v.cap < 18'd11) begin exp_err = 1; return; end
            push(hexc(w0[15:12])); push(hexc(w0[11:8])); push(hexc(w0[7:4]));
            push(hexc(w0[3:0])); push(hexc(w1[15:12])); push(hexc(w1[11:8]));
            push(8'h2D); push(8'h30); push(hexc(w1[7:4])); push(hexc(w1[3:0]));
            push(8'h00);
            return;
        end
        p = w1[7:0];
        exp_reads = 3;
        if (!v.erra[8] && v.erra[7:0] == p) begin exp_err = 3; return; end
        len = mem[p];
        if (len == 16'h0 || len == 16'hFFFF) begin exp_err = 2; return; end
        if (int'(v.cap) < 2 * int'(len) - 1) begin exp_err = 1; return; end
        for (int i = 1; i < int'(len); i++) begin
            logic [7:0] a;
            a = p + 8'(i);
            exp_reads++;
            if (!v.erra[8] && v.erra[7:0] == a) begin exp_err = 3; return; end
            push(mem[a][15:8]); push(mem[a][7:0]);
        end
        push(8'h00);
    endtask

    task automatic run(input vec_t v, input int idx);
        int    t;
        string tag;
        int    bad;
        @(negedge clk);
        nreads = 0; ndone = 0; ngot = 0; stab_bad = 0;
        cur_lat = v.lat; cur_erra = v.erra;
        guard_word = v.guard; first_addr = AW'(v.off0); second_addr = AW'(v.off1);
        capacity = v.cap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (ndone == 0 && t < 3000) begin @(negedge clk); t++; end
        repeat (8) @(negedge clk);
        model(v);
        tag = $sformatf("vec%0d", idx);
        chk("R1", {tag, " first addr"}, int'(a0), int'(v.off0));
        if (exp_reads >= 2) chk("R1", {tag, " second addr"}, int'(a1), int'(v.off1));
        chk("R8", {tag, " read count"}, nreads, exp_reads);
        chk("R9", {tag, " done pulses"}, ndone, 1);
        chk("R9", {tag, " result code"}, int'(got_err), exp_err);
        chk("R10", {tag, " request hold"}, stab_bad, 0);
        chk("R7", {tag, " byte count"}, ngot, nexp);
        bad = -1;
        for (int k = 0; k < nexp && k < ngot; k++)
            if (bad < 0 && got[k] != expb[k]) bad = k;
        if (bad >= 0) chk("R2", {tag, $sformatf(" byte %0d", bad)}, int'(got[bad]), int'(expb[bad]));
        else chk("R3", {tag, " bytes"}, 0, 0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[0]  = 16'h12AB; mem[1]  = 16'hCD3F;
        mem[2]  = 16'hFAFA; mem[3]  = 16'h0010;
        mem[4]  = 16'hFAFA; mem[5]  = 16'h0020;
        mem[6]  = 16'hFAFA; mem[7]  = 16'h0021;
        mem[8]  = 16'hFAFA; mem[9]  = 16'h0022;
        mem[10] = 16'h9A0F; mem[11] = 16'hF09A;
        mem[16] = 16'd3; mem[17] = 16'h4142; mem[18] = 16'h4344;
        mem[32] = 16'h0000; mem[33] = 16'hFFFF; mem[34] = 16'd1;
        mem[63] = 16'd2; mem[64] = 16'h5A30;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: quiet outputs under reset
        chk("R11", "reset req valid", int'(rd_req_valid), 0);
        chk("R11", "reset out valid", int'(out_valid), 0);
        chk("R11", "reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11", "post-reset req valid", int'(rd_req_valid), 0);

        for (int i = 0; i < NV; i++) run(VECS[i], i);

        // R11: reset in the middle of a run returns the block to quiet
        cur_lat = 4'd4; cur_erra = 9'h100;
        guard_word = 16'hFAFA; first_addr = 16'd2; second_addr = 16'd3; capacity = 18'd9;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "mid-run reset req valid", int'(rd_req_valid), 0);
        chk("R11", "mid-run reset done", int'(done), 0);
        rst_n = 1'b1;
        ndone = 0; ngot = 0;
        repeat (20) @(negedge clk);
        chk("R11", "no done after reset", ndone, 0);
        chk("R11", "no bytes after reset", ngot, 0);
        run(VECS[0], 99);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule